// File: doc/BRIEF.md
# Coprocessor Escape Dispatch and Wait Synchronizer

This block sits beside the fetch stage of a host processor that shares its instruction stream with a numeric coprocessor. Each opcode byte that arrives with a valid strobe is sorted into one of three classes. Escape bytes are handed to the coprocessor. The WAIT byte makes the host poll the coprocessor's busy line. Every other byte belongs to the host and passes straight through. Arithmetic itself is not modelled. A programmable latency stands in for the execution time, and busy stays high for that long.

The coprocessor can run only one instruction at a time. Code that follows the convention of placing a WAIT byte in front of every escape instruction is therefore serialized: the WAIT holds the fetch stage until busy drops, and the escape that follows is issued into an idle unit. An escape that reaches the block while the unit is still busy, with no WAIT before it, is consumed and dropped. The block then raises a protocol-error pulse.

Top module: `cop_dispatch_sync`

## Requirements
- R1: After reset, cop_busy, cop_done, fetch_stall and proto_err are all 0.
- R2: A valid byte whose upper five bits are 5'b11011 (8'hD8 to 8'hDF) is an escape. When the unit is idle, an escape raises cop_issue and op_accept in the same cycle. No other byte ever raises cop_issue.
- R3: cop_busy rises on the clock edge that follows an issue. It stays high for exactly lat_cycles+1 cycles, using the lat_cycles value sampled at the issue.
- R4: cop_done is high only in the last cycle in which cop_busy is high.
- R5: A valid byte 8'h9B (WAIT) presented while cop_busy is high holds fetch_stall=1 and op_accept=0 in every busy cycle. It is accepted, with fetch_stall=0, in the first cycle in which cop_busy is low.
- R6: A WAIT presented while cop_busy is low is accepted in the same cycle with no stall.
- R7: An escape presented while cop_busy is high is accepted and dropped, with no cop_issue. proto_err is 1 in the following cycle, and the running instruction's busy length does not change.
- R8: A valid byte that is neither an escape nor a WAIT is accepted in the same cycle, busy or not, and leaves cop_busy unchanged.
- R9: An escape presented in the cycle after a WAIT completes is issued with no protocol error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Opcode byte is present |
| op_byte | input | 8 | Fetched opcode byte |
| lat_cycles | input | LAT_W | Execution latency loaded at issue |
| op_accept | output | 1 | Fetch stage may advance past this byte |
| fetch_stall | output | 1 | WAIT is holding the fetch stage |
| cop_issue | output | 1 | Escape handed to the coprocessor this cycle |
| cop_busy | output | 1 | Coprocessor executing (drives the host test input) |
| cop_done | output | 1 | Last busy cycle of the running instruction |
| proto_err | output | 1 | Escape was dropped while busy (one-cycle pulse) |

## Verification
op_accept, fetch_stall and cop_issue are combinational in the current byte and busy. The bench drives each byte on a falling edge and reads these three outputs 1 ns later, within that same cycle. cop_busy appears one edge after the issue, and proto_err one edge after the offending escape, so each of these is read after the next falling edge. Busy length is measured by counting falling-edge samples until cop_busy reads 0, and the count is compared with lat_cycles+1. cop_done is checked at each of those samples against whether that sample is the last expected one.

// File: rtl/cds_pkg.sv
package cds_pkg;
  typedef enum logic [1:0] {OPC_HOST, OPC_ESC, OPC_WAIT} opc_class_e;

  localparam logic [7:0] WAIT_BYTE  = 8'h9B;
  localparam logic [4:0] ESC_PREFIX = 5'b11011;

  function automatic opc_class_e classify(input logic [7:0] b);
    if (b[7:3] == ESC_PREFIX) return OPC_ESC;
    if (b == WAIT_BYTE)       return OPC_WAIT;
    return OPC_HOST;
  endfunction
endpackage

// File: rtl/cds_decode.sv
module cds_decode
  import cds_pkg::*;
(
  input  logic       op_valid,
  input  logic [7:0] op_byte,
  output logic       is_esc,
  output logic       is_wait
);
  opc_class_e cls;

  always_comb begin
    cls     = classify(op_byte);
    is_esc  = op_valid && (cls == OPC_ESC);
    is_wait = op_valid && (cls == OPC_WAIT);
  end

  always_comb begin
    a_excl_r2: assert (!(is_esc && is_wait));
  end
endmodule

// File: rtl/cds_lat_timer.sv
module cds_lat_timer #(
  parameter int LAT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LAT_W-1:0] lat_in,
  output logic             busy,
  output logic             done
);
  logic [LAT_W-1:0] remain;

  assign done = busy && (remain == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      remain <= '0;
    end else if (start && !busy) begin
      busy   <= 1'b1;
      remain <= lat_in;
    end else if (busy) begin
      if (remain == '0) busy <= 1'b0;
      else              remain <= remain - 1'b1;
    end
  end

  p_busy_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  p_busy_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
  p_done_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
endmodule

// File: rtl/cop_dispatch_sync.sv
module cop_dispatch_sync #(
  parameter int LAT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic [7:0]       op_byte,
  input  logic [LAT_W-1:0] lat_cycles,
  output logic             op_accept,
  output logic             fetch_stall,
  output logic             cop_issue,
  output logic             cop_busy,
  output logic             cop_done,
  output logic             proto_err
);
  logic is_esc, is_wait;
  logic esc_collide;
  logic test_n;

  cds_decode u_dec (
    .op_valid (op_valid),
    .op_byte  (op_byte),
    .is_esc   (is_esc),
    .is_wait  (is_wait)
  );

  cds_lat_timer #(.LAT_W(LAT_W)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (cop_issue),
    .lat_in (lat_cycles),
    .busy   (cop_busy),
    .done   (cop_done)
  );

  // host test input: high means coprocessor still running
  assign test_n      = cop_busy;
  assign fetch_stall = is_wait && test_n;
  assign op_accept   = op_valid && !fetch_stall;
  assign cop_issue   = is_esc && !cop_busy;
  assign esc_collide = is_esc && cop_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) proto_err <= 1'b0;
    else        proto_err <= esc_collide;
  end

  p_no_issue_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cop_busy |-> !cop_issue);
  p_err_after_collide_r7: assert property (@(posedge clk) disable iff (!rst_n)
    esc_collide |=> proto_err);
  p_stall_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_stall |-> (cop_busy && !op_accept));
  p_wait_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (is_wait && !cop_busy) |-> op_accept);
endmodule

// File: tb/test_cop_dispatch_sync.sv
module test_cop_dispatch_sync;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [7:0] op_byte = 8'h00;
  logic [7:0] lat_cycles = 8'd0;
  logic op_accept, fetch_stall, cop_issue, cop_busy, cop_done, proto_err;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  cop_dispatch_sync #(.LAT_W(8)) i_cop_dispatch_sync (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_byte(op_byte),
    .lat_cycles(lat_cycles), .op_accept(op_accept), .fetch_stall(fetch_stall),
    .cop_issue(cop_issue), .cop_busy(cop_busy), .cop_done(cop_done),
    .proto_err(proto_err)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step;
    @(negedge clk);
    #1;
  endtask

  // leaves bench in the first busy cycle
  task automatic issue_esc(input logic [7:0] b, input logic [7:0] lat);
    @(negedge clk);
    op_valid = 1'b1; op_byte = b; lat_cycles = lat;
    #1;
    check("R2 issue", cop_issue, 1);
    check("R2 accept", op_accept, 1);
    step();
    op_valid = 1'b0;
    lat_cycles = 8'd200;
    #1;
    check("R3 busy rise", cop_busy, 1);
  endtask

  task automatic count_busy(input int start_n, input int lat);
    int n = start_n - 1;
    while (cop_busy && n < 400) begin
      n++;
      check("R4 done", cop_done, (n == lat + 1) ? 1 : 0);
      step();
    end
    check("R3 busy length", n, lat + 1);
  endtask

  task automatic t_reset;
    repeat (3) step();
    check("R1 busy", cop_busy, 0);
    check("R1 done", cop_done, 0);
    check("R1 stall", fetch_stall, 0);
    check("R1 err", proto_err, 0);
    rst_n = 1'b1;
    step();
  endtask

  task automatic t_lengths;
    issue_esc(8'hD8, 8'd0); count_busy(1, 0);
    issue_esc(8'hDF, 8'd3); count_busy(1, 3);
    issue_esc(8'hDC, 8'd12); count_busy(1, 12);
  endtask

  task automatic t_host_bytes;
    logic [7:0] bytes [7] = '{8'h00, 8'h90, 8'h9A, 8'h9C, 8'hD7, 8'hE0, 8'hFF};
    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      op_valid = 1'b1; op_byte = bytes[i];
      #1;
      check("R8 accept idle", op_accept, 1);
      check("R2 no issue", cop_issue, 0);
      check("R8 no stall", fetch_stall, 0);
      step();
      check("R8 busy stays low", cop_busy, 0);
    end
    op_valid = 1'b0;
    issue_esc(8'hDB, 8'd3);
    op_valid = 1'b1; op_byte = 8'h90;
    #1;
    check("R8 accept busy", op_accept, 1);
    check("R8 no issue busy", cop_issue, 0);
    step();
    op_valid = 1'b0;
    #1;
    count_busy(2, 3);
  endtask

  task automatic t_wait_idle;
    @(negedge clk);
    op_valid = 1'b1; op_byte = 8'h9B;
    #1;
    check("R6 accept", op_accept, 1);
    check("R6 stall", fetch_stall, 0);
    check("R6 no issue", cop_issue, 0);
    step();
    op_valid = 1'b0;
  endtask

  task automatic t_wait_busy;
    int n = 1;
    issue_esc(8'hD9, 8'd5);
    op_valid = 1'b1; op_byte = 8'h9B;
    #1;
    while (cop_busy && n < 400) begin
      check("R5 stall", fetch_stall, 1);
      check("R5 hold", op_accept, 0);
      step();
      if (cop_busy) n++;
    end
    check("R3 busy length under wait", n, 6);
    check("R5 accept after", op_accept, 1);
    check("R5 stall off", fetch_stall, 0);
    step();
    op_byte = 8'hDE; lat_cycles = 8'd2;
    #1;
    check("R9 issue", cop_issue, 1);
    step();
    op_valid = 1'b0;
    #1;
    check("R9 no error", proto_err, 0);
    check("R9 busy", cop_busy, 1);
    count_busy(1, 2);
  endtask

  task automatic t_collide;
    issue_esc(8'hDA, 8'd4);
    op_valid = 1'b1; op_byte = 8'hDD;
    #1;
    check("R7 accept", op_accept, 1);
    check("R7 no issue", cop_issue, 0);
    step();
    op_valid = 1'b0;
    #1;
    check("R7 err pulse", proto_err, 1);
    count_busy(2, 4);
    check("R7 err cleared", proto_err, 0);
  endtask

  initial begin
    t_reset();
    t_lengths();
    t_host_bytes();
    t_wait_idle();
    t_wait_busy();
    t_collide();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule